// File: doc/BRIEF.md
# Dual-Bank Interrupt Aggregator

This block collects sixty-four interrupt request lines and folds them into one request line for the CPU. The lines are split into two banks of thirty-two. Each bank keeps four words of state. The first holds latched events from rising inputs. The second is an enable mask. The third is a copy of the current input levels. The fourth marks which bits follow their level instead of latching an edge. A bank raises a pending request when any enabled bit has a latched event, or has a level-mode input that is high. The CPU line is high while either bank has a pending request.

Software uses a plain 32-bit register port with a select and a write strobe. It reads the events, the mask and the levels of each bank. It writes the mask, and it clears events by writing ones. A clear never affects a bit that is in level mode. The interrupt inputs run on the bus clock. Read data is combinational from the selected register. The register port carries single-cycle accesses that always complete. There is no valid/ready handshake and no back-pressure.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset, every readable register returns zero and `irq_out` is low.
- R2: Input line n belongs to bank 1 − (n / 32), at bit n mod 32. Lines 0..31 land in bank 1 and lines 32..63 land in bank 0.
- R3: On the clock edge where an input is first seen high, its levels bit becomes 1. Its events bit also becomes 1, unless that bit is in level mode.
- R4: When an input falls, only its levels bit returns to 0. A latched events bit stays set.
- R5: A write to the clear register (word offset 0x8) zeroes each events bit that is written as 1 and is not in level mode. Level-mode bits are left alone. The clear register reads as zero.
- R6: A write to the mask register (word offset 0x4) replaces the whole mask of that bank. The new value reads back from the same address.
- R7: `irq_out` is registered. Its value is high exactly when, in the previous cycle, some bank had a nonzero value of (events OR (levels AND level_mode)) AND mask.
- R8: Only the low 12 address bits are decoded. Bank k occupies bytes 0x10+16k to 0x1F+16k. Within a bank, word offset 0x0 is events, 0x4 is mask, 0x8 is clear and 0xC is levels, and address bits 1:0 are ignored. Reads outside the two bank windows return zero. Writes outside the windows, and writes to events or levels, have no effect.
- R9: After reset, bank 1 has bits 20 through 28 in level mode (0x1FF00000), so lines 20..28 never latch an event. Bank 0 has no level-mode bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and interrupt clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt request lines, synchronous to clk |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address; low 12 bits are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| irq_out | output | 1 | Combined interrupt request to the CPU |

## Verification
An input change or a register write is taken on one clock edge and shows up on the register reads right after that edge. `irq_out` follows one edge later. After each write or input change, the bench waits for the falling edge before it samples reads. For `irq_out` checks it waits one more cycle. A behavioural reference model tracks the same state at every rising edge, and `irq_out` is compared against the model on every falling edge. This keeps the two-stage latency under check in every cycle, including the cycles where a level-mode input falls and the request must drop.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    REG_EVENTS = 2'd0,
    REG_MASK   = 2'd1,
    REG_CLEAR  = 2'd2,
    REG_LEVELS = 2'd3
  } intc_reg_e;

  // Level-mode bits each bank carries out of reset.
  function automatic logic [31:0] lt_reset_word(input int bank);
    return (bank == 1) ? 32'h1FF0_0000 : 32'h0000_0000;
  endfunction

endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_BANKS = 2,
  localparam int BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [BIDX_W-1:0] bank_idx,
  output intc_reg_e         reg_sel
);
  logic [11:0] a12;
  logic [11:0] rel;

  assign a12      = addr[11:0];
  assign rel      = a12 - 12'h010;
  assign hit      = (a12 >= 12'h010) && (rel[11:4] < 8'(NUM_BANKS));
  assign bank_idx = rel[4 +: BIDX_W];
  assign reg_sel  = intc_reg_e'(a12[3:2]);
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int           W       = 32,
  parameter logic [W-1:0] LT_INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_bits,
  input  logic         mask_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] events,
  output logic [W-1:0] mask,
  output logic [W-1:0] levels,
  output logic         pending
);
  logic [W-1:0] rise_bits;
  logic [W-1:0] set_bits;
  logic [W-1:0] clr_bits;

  assign rise_bits = in_bits & ~levels;
  assign set_bits  = rise_bits & ~LT_INIT;
  assign clr_bits  = clr_we ? (wdata & ~LT_INIT) : '0;
  assign pending   = |((events | (levels & LT_INIT)) & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      events <= '0;
      mask   <= '0;
      levels <= '0;
    end else begin
      levels <= in_bits;
      events <= (events & ~clr_bits) | set_bits;
      if (mask_we) mask <= wdata;
    end
  end

  // R3 / R9: a level-mode bit never holds a latched event
  a_r9_no_event_in_level_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (events & LT_INIT) == '0);

  // R4: with no clear write, latched events only accumulate
  a_r4_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((events & $past(events)) == $past(events)));

  // R5: a clear never removes a bit that was not written as 1
  a_r5_clear_selective: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((events & $past(events & ~wdata)) == $past(events & ~wdata)));

  // R6: a mask write takes the written word in full
  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask == $past(wdata)));
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 2,
  localparam int NUM_IRQ  = NUM_BANKS * DATA_W,
  localparam int BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_out
);
  logic              hit;
  logic [BIDX_W-1:0] bank_idx;
  intc_reg_e         reg_sel;

  logic [DATA_W-1:0] ev_w  [NUM_BANKS];
  logic [DATA_W-1:0] mk_w  [NUM_BANKS];
  logic [DATA_W-1:0] lv_w  [NUM_BANKS];
  logic [NUM_BANKS-1:0] pend;
  logic [NUM_BANKS-1:0] mask_we;
  logic [NUM_BANKS-1:0] clr_we;

  intc_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .addr(bus_addr), .hit(hit), .bank_idx(bank_idx), .reg_sel(reg_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign mask_we[b] = bus_sel && bus_we && hit &&
                        (bank_idx == BIDX_W'(b)) && (reg_sel == REG_MASK);
    assign clr_we[b]  = bus_sel && bus_we && hit &&
                        (bank_idx == BIDX_W'(b)) && (reg_sel == REG_CLEAR);

    intc_bank #(.W(DATA_W), .LT_INIT(DATA_W'(lt_reset_word(b)))) u_bank (
      .clk(clk), .rst_n(rst_n),
      .in_bits(irq_in[(NUM_BANKS-1-b)*DATA_W +: DATA_W]),
      .mask_we(mask_we[b]), .clr_we(clr_we[b]), .wdata(bus_wdata),
      .events(ev_w[b]), .mask(mk_w[b]), .levels(lv_w[b]), .pending(pend[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we && hit) begin
      case (reg_sel)
        REG_EVENTS: bus_rdata = ev_w[bank_idx];
        REG_MASK:   bus_rdata = mk_w[bank_idx];
        REG_LEVELS: bus_rdata = lv_w[bank_idx];
        default:    bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= |pend;
  end

  // R7: the output follows the bank requests one cycle later
  a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |=> irq_out);
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> !irq_out);

  // R8: at most one bank takes any given write
  a_r8_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_we | clr_we));

  // R8: nothing reads back outside a decoded window
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (bus_rdata == '0));
endmodule

// File: tb/tb_dual_bank_intc.sv
module tb_dual_bank_intc;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] irq_in = '0;
  logic        bus_sel = 0;
  logic        bus_we = 0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  dual_bank_intc dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #5 clk = ~clk;

  // Behavioural reference model
  bit [31:0] m_ev [2] = '{0, 0};
  bit [31:0] m_mk [2] = '{0, 0};
  bit [31:0] m_lv [2] = '{0, 0};
  bit [31:0] m_lt [2] = '{32'h0, 32'h1FF0_0000};
  bit        m_irq = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin m_ev[k] = 0; m_mk[k] = 0; m_lv[k] = 0; end
      m_irq = 0;
    end else begin
      bit [31:0] a;
      m_irq = (((m_ev[0] | (m_lv[0] & m_lt[0])) & m_mk[0]) != 0) ||
              (((m_ev[1] | (m_lv[1] & m_lt[1])) & m_mk[1]) != 0);
      a = bus_addr & 32'hFFF;
      if (bus_sel && bus_we && a >= 32'h10 && a < 32'h30) begin
        int bk;
        bk = int'((a - 32'h10) >> 4);
        if ((a & 32'hC) == 32'h4) m_mk[bk] = bus_wdata;
        if ((a & 32'hC) == 32'h8) m_ev[bk] = m_ev[bk] & ~(bus_wdata & ~m_lt[bk]);
      end
      for (int n = 0; n < 64; n++) begin
        int bk; int bt;
        bk = 1 - n / 32; bt = n % 32;
        if (irq_in[n] && !m_lv[bk][bt] && !m_lt[bk][bt]) m_ev[bk][bt] = 1'b1;
        m_lv[bk][bt] = irq_in[n];
      end
    end
  end

  // R7: compare the output with the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_run++;
      if (irq_out !== m_irq) begin
        n_fail++;
        $display("FAIL R7 per-cycle irq_out: actual %0b expected %0b at %0t", irq_out, m_irq, $time);
      end
    end
  end

  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1;
    n_run++;
    if (bus_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s read 0x%0h: actual 0x%08h expected 0x%08h", tag, a, bus_rdata, exp);
    end
    bus_sel = 0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic set_line(input int n, input logic v);
    @(negedge clk);
    irq_in[n] = v;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    #1;
    n_run++;
    if (irq_out !== exp) begin
      n_fail++;
      $display("FAIL %s irq_out: actual %0b expected %0b", tag, irq_out, exp);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(32'h10, 32'h0, "R1"); rd(32'h14, 32'h0, "R1"); rd(32'h1C, 32'h0, "R1");
    rd(32'h20, 32'h0, "R1"); rd(32'h24, 32'h0, "R1"); rd(32'h2C, 32'h0, "R1");
    // R2 R3: line 3 goes to bank 1 bit 3
    set_line(3, 1'b1);
    rd(32'h20, 32'h8, "R3"); rd(32'h2C, 32'h8, "R3"); rd(32'h10, 32'h0, "R2");
    // R4: falling input keeps the event
    set_line(3, 1'b0);
    rd(32'h2C, 32'h0, "R4"); rd(32'h20, 32'h8, "R4");
    // R6 R7: mask enables the latched event
    wr(32'h24, 32'h8);
    rd(32'h24, 32'h8, "R6");
    chk_irq(1'b1, "R7");
    // R5: clear all
    wr(32'h28, 32'hFFFF_FFFF);
    rd(32'h20, 32'h0, "R5"); rd(32'h28, 32'h0, "R5");
    chk_irq(1'b0, "R7");
    // R2: line 40 goes to bank 0 bit 8
    set_line(40, 1'b1);
    rd(32'h10, 32'h100, "R2"); rd(32'h1C, 32'h100, "R2"); rd(32'h20, 32'h0, "R2");
    // R9: line 20 is level mode in bank 1
    set_line(20, 1'b1);
    rd(32'h20, 32'h0, "R9"); rd(32'h2C, 32'h0010_0000, "R9");
    wr(32'h24, 32'h0010_0000);
    chk_irq(1'b1, "R9");
    wr(32'h28, 32'h0010_0000);
    chk_irq(1'b1, "R5");
    set_line(20, 1'b0);
    @(negedge clk);
    chk_irq(1'b0, "R9");
    // R8: aliasing, read-only and unmapped addresses
    wr(32'h0000_1014, 32'h100);
    rd(32'h14, 32'h100, "R8");
    wr(32'h1C, 32'hFFFF_FFFF);
    rd(32'h1C, 32'h100, "R8");
    wr(32'h10, 32'h0);
    rd(32'h10, 32'h100, "R8");
    wr(32'h30, 32'hFFFF_FFFF);
    wr(32'h04, 32'hFFFF_FFFF);
    rd(32'h24, 32'h0010_0000, "R8"); rd(32'h14, 32'h100, "R8");
    rd(32'h30, 32'h0, "R8"); rd(32'h00, 32'h0, "R8"); rd(32'h16, 32'h100, "R8");
    chk_irq(1'b1, "R7");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule